// File: doc/BRIEF.md
# Machine Timer with Prescaled Step Counter

This block is a single-hart machine timer that sits on a simple 32-bit register bus made of an address, a write enable, write data and a combinational read data return. It keeps a 64-bit time counter and a 64-bit compare value. Software reaches each of them as a low and a high 32-bit half. The counter runs only while the active bit in the control register is set. A prescale divider produces a tick every prescale+1 clocks, and each tick adds a programmable step to the counter.

The timer has expired when the counter is at or past the compare value. The machine-timer line follows that condition level by level while the timer is active. A separate sticky interrupt-state bit records each expiry and drives the expired interrupt output through an enable bit. Software clears the bit by writing 1 to it, and a test register can set it on demand.

Top module: `mach_timer`

## Requirements
- R1: After reset, reads return 0 at control (0x004), 0x0001_0000 at config (0x100), 0 at counter low (0x104) and high (0x108), 0xFFFF_FFFF at compare low (0x10C) and high (0x110), 0 at interrupt enable (0x114) and interrupt state (0x118). Both interrupt outputs are low.
- R2: While control bit 0 (active) is 0, the counter keeps its value for any number of cycles.
- R3: A write to counter low or counter high replaces that half, and the value reads back. A counter write on a tick edge takes priority over the increment, so no step is added on that edge.
- R4: Config reads back every written bit unchanged. Bits [11:0] hold the prescale value and bits [23:16] the step. While the timer is active, a tick occurs on every (prescale+1)-th clock and adds the step to the full 64-bit counter, with carry from the low half into the high half.
- R5: Compare low and compare high are writable and read back the written value.
- R6: The machine-timer output is high exactly when the timer is active and the 64-bit counter is greater than or equal to the 64-bit compare value. It follows a compare write on the next cycle and falls when the compare value moves ahead of the counter.
- R7: Interrupt state bit 0 is set on the clock edge after the expired condition is present, and it stays set until software writes 1 to bit 0 at 0x118. If a set and a clear fall on the same edge, the set wins.
- R8: Writing 1 to bit 0 of interrupt test (0x11C) sets interrupt state bit 0. Interrupt test and alert test (0x000) always read 0.
- R9: The expired interrupt output equals interrupt state bit 0 ANDed with interrupt enable bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busAddr | input | ADDR_W (12) | Byte address of the register |
| busWe | input | 1 | Write enable; the write takes effect on the rising edge |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr, combinational |
| intrExpired | output | 1 | Sticky expired interrupt, gated by the enable bit |
| machTimerIrq | output | 1 | Level machine-timer interrupt: active and counter >= compare |

## Verification
The bench sweeps prescale values 0 to 3 against several steps and computes the counter from the exact number of active clock edges. An off-by-one in the prescale divider or in the tick gating shows up as a wrong count. One run starts just below the 32-bit boundary, so a counter that loses the carry into the high half returns a wrong high word. Other cases write the counter on a running tick edge, where a design that lets the increment win reads back one more than the written value. The bench also steps the compare value behind and then ahead of the counter to check that the level output tracks it while the state bit stays set. It finally checks that the clear-by-one and the test-set paths move only the state bit, and that a masked enable blocks the expired output.

// File: rtl/mach_timer_pkg.sv
package mach_timer_pkg;

  localparam int BUS_W = 32;

  localparam logic [11:0] OFF_ALERT  = 12'h000;
  localparam logic [11:0] OFF_CTRL   = 12'h004;
  localparam logic [11:0] OFF_CFG    = 12'h100;
  localparam logic [11:0] OFF_CNT_LO = 12'h104;
  localparam logic [11:0] OFF_CNT_HI = 12'h108;
  localparam logic [11:0] OFF_CMP_LO = 12'h10C;
  localparam logic [11:0] OFF_CMP_HI = 12'h110;
  localparam logic [11:0] OFF_IEN    = 12'h114;
  localparam logic [11:0] OFF_ISTATE = 12'h118;
  localparam logic [11:0] OFF_ITEST  = 12'h11C;

  typedef enum logic [3:0] {
    SEL_ZERO,
    SEL_CTRL,
    SEL_CFG,
    SEL_CNT_LO,
    SEL_CNT_HI,
    SEL_CMP_LO,
    SEL_CMP_HI,
    SEL_IEN,
    SEL_ISTATE
  } rdSel_e;

  typedef struct packed {
    logic wrCtrl;
    logic wrCfg;
    logic wrCntLo;
    logic wrCntHi;
    logic wrCmpLo;
    logic wrCmpHi;
    logic wrIen;
    logic clrState;
    logic setTest;
  } regStb_t;

endpackage

// File: rtl/mach_timer_ctrl.sv
module mach_timer_ctrl
  import mach_timer_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic              wdataBit0,
  output regStb_t           stb,
  output rdSel_e            rdSel
);

  logic hitCtrl, hitCfg, hitCntLo, hitCntHi, hitCmpLo, hitCmpHi;
  logic hitIen, hitIstate, hitItest;

  always_comb begin
    hitCtrl   = (busAddr == ADDR_W'(OFF_CTRL));
    hitCfg    = (busAddr == ADDR_W'(OFF_CFG));
    hitCntLo  = (busAddr == ADDR_W'(OFF_CNT_LO));
    hitCntHi  = (busAddr == ADDR_W'(OFF_CNT_HI));
    hitCmpLo  = (busAddr == ADDR_W'(OFF_CMP_LO));
    hitCmpHi  = (busAddr == ADDR_W'(OFF_CMP_HI));
    hitIen    = (busAddr == ADDR_W'(OFF_IEN));
    hitIstate = (busAddr == ADDR_W'(OFF_ISTATE));
    hitItest  = (busAddr == ADDR_W'(OFF_ITEST));
  end

  always_comb begin
    stb.wrCtrl   = busWe && hitCtrl;
    stb.wrCfg    = busWe && hitCfg;
    stb.wrCntLo  = busWe && hitCntLo;
    stb.wrCntHi  = busWe && hitCntHi;
    stb.wrCmpLo  = busWe && hitCmpLo;
    stb.wrCmpHi  = busWe && hitCmpHi;
    stb.wrIen    = busWe && hitIen;
    stb.clrState = busWe && hitIstate && wdataBit0;
    stb.setTest  = busWe && hitItest && wdataBit0;
  end

  // Alert test, interrupt test and unmapped addresses all fall to zero.
  always_comb begin
    rdSel = SEL_ZERO;
    if (hitCtrl)   rdSel = SEL_CTRL;
    if (hitCfg)    rdSel = SEL_CFG;
    if (hitCntLo)  rdSel = SEL_CNT_LO;
    if (hitCntHi)  rdSel = SEL_CNT_HI;
    if (hitCmpLo)  rdSel = SEL_CMP_LO;
    if (hitCmpHi)  rdSel = SEL_CMP_HI;
    if (hitIen)    rdSel = SEL_IEN;
    if (hitIstate) rdSel = SEL_ISTATE;
  end

endmodule

// File: rtl/mach_timer_tick.sv
module mach_timer_tick #(
  parameter int PRE_W = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             active,
  input  logic [PRE_W-1:0] prescale,
  output logic             tick
);

  logic [PRE_W-1:0] divCnt;

  // ">=" keeps the divider bounded if prescale shrinks mid-count.
  assign tick = active && (divCnt >= prescale);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          divCnt <= '0;
    else if (!active)   divCnt <= '0;
    else if (tick)      divCnt <= '0;
    else                divCnt <= divCnt + PRE_W'(1);
  end

endmodule

// File: rtl/mach_timer_dp.sv
module mach_timer_dp
  import mach_timer_pkg::*;
#(
  parameter int PRE_W    = 12,
  parameter int PRE_LSB  = 0,
  parameter int STEP_W   = 8,
  parameter int STEP_LSB = 16,
  parameter logic [BUS_W-1:0] CFG_RESET = 32'h0001_0000
) (
  input  logic             clk,
  input  logic             rstN,
  input  regStb_t          stb,
  input  rdSel_e           rdSel,
  input  logic [BUS_W-1:0] busWdata,
  output logic [BUS_W-1:0] busRdata,
  output logic [2*BUS_W-1:0] cntVal,
  output logic             activeQ,
  output logic             stateQ,
  output logic             enQ,
  output logic             expired
);

  localparam int HALVES = 2;
  localparam int CNT_W  = HALVES * BUS_W;

  logic [BUS_W-1:0] cfgQ;
  logic [CNT_W-1:0] cmpQ;
  logic [HALVES-1:0] cntWr, cmpWr;
  logic [PRE_W-1:0] prescale;
  logic [STEP_W-1:0] stepVal;
  logic tick;

  assign prescale = cfgQ[PRE_LSB +: PRE_W];
  assign stepVal  = cfgQ[STEP_LSB +: STEP_W];
  assign cntWr    = {stb.wrCntHi, stb.wrCntLo};
  assign cmpWr    = {stb.wrCmpHi, stb.wrCmpLo};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeQ <= 1'b0;
      enQ     <= 1'b0;
      cfgQ    <= CFG_RESET;
    end else begin
      if (stb.wrCtrl) activeQ <= busWdata[0];
      if (stb.wrIen)  enQ     <= busWdata[0];
      if (stb.wrCfg)  cfgQ    <= busWdata;
    end
  end

  mach_timer_tick #(.PRE_W(PRE_W)) tick_i (
    .clk     (clk),
    .rstN    (rstN),
    .active  (activeQ),
    .prescale(prescale),
    .tick    (tick)
  );

  // Counter: any half write suppresses the increment for that edge.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntVal <= '0;
    end else if (|cntWr) begin
      for (int h = 0; h < HALVES; h++) begin
        if (cntWr[h]) cntVal[h*BUS_W +: BUS_W] <= busWdata;
      end
    end else if (tick) begin
      cntVal <= cntVal + CNT_W'(stepVal);
    end
  end

  generate
    for (genvar h = 0; h < HALVES; h++) begin : g_cmp
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)         cmpQ[h*BUS_W +: BUS_W] <= '1;
        else if (cmpWr[h]) cmpQ[h*BUS_W +: BUS_W] <= busWdata;
      end
    end
  endgenerate

  assign expired = activeQ && (cntVal >= cmpQ);

  // Set has priority over a same-edge clear.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= 1'b0;
    else       stateQ <= (stateQ && !stb.clrState) || expired || stb.setTest;
  end

  always_comb begin
    unique case (rdSel)
      SEL_CTRL:   busRdata = {{(BUS_W-1){1'b0}}, activeQ};
      SEL_CFG:    busRdata = cfgQ;
      SEL_CNT_LO: busRdata = cntVal[0 +: BUS_W];
      SEL_CNT_HI: busRdata = cntVal[BUS_W +: BUS_W];
      SEL_CMP_LO: busRdata = cmpQ[0 +: BUS_W];
      SEL_CMP_HI: busRdata = cmpQ[BUS_W +: BUS_W];
      SEL_IEN:    busRdata = {{(BUS_W-1){1'b0}}, enQ};
      SEL_ISTATE: busRdata = {{(BUS_W-1){1'b0}}, stateQ};
      default:    busRdata = '0;
    endcase
  end

endmodule

// File: rtl/mach_timer.sv
module mach_timer
  import mach_timer_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int PRE_W    = 12,
  parameter int STEP_W   = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic              intrExpired,
  output logic              machTimerIrq
);

  regStb_t stb;
  rdSel_e  rdSel;
  logic [63:0] cntVal;
  logic activeQ, stateQ, enQ, expired;

  mach_timer_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .busAddr  (busAddr),
    .busWe    (busWe),
    .wdataBit0(busWdata[0]),
    .stb      (stb),
    .rdSel    (rdSel)
  );

  mach_timer_dp #(.PRE_W(PRE_W), .STEP_W(STEP_W)) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .rdSel   (rdSel),
    .busWdata(busWdata),
    .busRdata(busRdata),
    .cntVal  (cntVal),
    .activeQ (activeQ),
    .stateQ  (stateQ),
    .enQ     (enQ),
    .expired (expired)
  );

  assign machTimerIrq = expired;
  assign intrExpired  = stateQ && enQ;

endmodule

// File: rtl/mach_timer_chk.sv
module mach_timer_chk
  import mach_timer_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWe,
  input logic [31:0]       busWdata,
  input logic [63:0]       cntVal,
  input logic              activeQ,
  input logic              stateQ,
  input logic              enQ,
  input logic              intrExpired,
  input logic              machTimerIrq
);

  logic wrCnt, wrLo, clrHit, testHit;
  assign wrLo    = busWe && (busAddr == ADDR_W'(OFF_CNT_LO));
  assign wrCnt   = wrLo || (busWe && (busAddr == ADDR_W'(OFF_CNT_HI)));
  assign clrHit  = busWe && (busAddr == ADDR_W'(OFF_ISTATE)) && busWdata[0];
  assign testHit = busWe && (busAddr == ADDR_W'(OFF_ITEST)) && busWdata[0];

  // R2
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!activeQ && !wrCnt) |=> $stable(cntVal));

  // R3
  cnt_wr_lo_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrLo |=> (cntVal[31:0] == $past(busWdata)));

  // R6
  mtip_active_chk: assert property (@(posedge clk) disable iff (!rstN)
    machTimerIrq |-> activeQ);

  // R7
  state_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ && !clrHit) |=> stateQ);

  // R8
  test_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    testHit |=> stateQ);

  // R9
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enQ |-> !intrExpired);

endmodule

bind mach_timer mach_timer_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk         (clk),
  .rstN        (rstN),
  .busAddr     (busAddr),
  .busWe       (busWe),
  .busWdata    (busWdata),
  .cntVal      (cntVal),
  .activeQ     (activeQ),
  .stateQ      (stateQ),
  .enQ         (enQ),
  .intrExpired (intrExpired),
  .machTimerIrq(machTimerIrq)
);

// File: tb/mach_timer_tb_top.sv
`timescale 1ns/100ps
module mach_timer_tb_top;

  localparam logic [11:0] A_ALERT = 12'h000, A_CTRL = 12'h004, A_CFG = 12'h100,
    A_CLO = 12'h104, A_CHI = 12'h108, A_MLO = 12'h10C, A_MHI = 12'h110,
    A_IEN = 12'h114, A_IST = 12'h118, A_ITST = 12'h11C;

  logic clk = 1'b0, rstN = 1'b0, busWe = 1'b0;
  logic [11:0] busAddr = '0;
  logic [31:0] busWdata = '0, busRdata;
  logic intrExpired, machTimerIrq;
  int errors = 0, checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  mach_timer dut_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata),
    .intrExpired(intrExpired), .machTimerIrq(machTimerIrq)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    busAddr = a;
    #1;
    d = busRdata;
  endtask

  // Run with given start, prescale, step for M idle edges; return final count.
  task automatic run(input logic [63:0] start, input int p, input int st,
                     input int m, output logic [63:0] res);
    logic [31:0] lo, hi;
    wr(A_CTRL, 0);
    wr(A_CFG, (st << 16) | p);
    wr(A_CLO, start[31:0]);
    wr(A_CHI, start[63:32]);
    wr(A_CTRL, 1);
    repeat (m) @(posedge clk);
    wr(A_CTRL, 0);
    rd(A_CLO, lo);
    rd(A_CHI, hi);
    res = {hi, lo};
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [63:0] r;
    bit sticky;
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R1 reset state
    rd(A_CTRL, v); chk("R1 ctrl", v, 0);
    rd(A_CFG, v);  chk("R1 cfg", v, 32'h0001_0000);
    rd(A_CLO, v);  chk("R1 cnt lo", v, 0);
    rd(A_CHI, v);  chk("R1 cnt hi", v, 0);
    rd(A_MLO, v);  chk("R1 cmp lo", v, 32'hFFFF_FFFF);
    rd(A_MHI, v);  chk("R1 cmp hi", v, 32'hFFFF_FFFF);
    rd(A_IEN, v);  chk("R1 ien", v, 0);
    rd(A_IST, v);  chk("R1 istate", v, 0);
    chk("R1 intrExpired", intrExpired, 0);
    chk("R1 machTimerIrq", machTimerIrq, 0);

    // R2 inactive hold
    repeat (40) @(posedge clk);
    rd(A_CLO, v); chk("R2 idle after reset", v, 0);
    wr(A_CLO, 32'h55);
    repeat (50) @(posedge clk);
    rd(A_CLO, v); chk("R2 idle hold", v, 32'h55);

    // R3 / R5 / R4 readback
    wr(A_CHI, 32'h0BAD_0123); rd(A_CHI, v); chk("R3 cnt hi rb", v, 32'h0BAD_0123);
    wr(A_CLO, 32'h7654_3210); rd(A_CLO, v); chk("R3 cnt lo rb", v, 32'h7654_3210);
    wr(A_MLO, 32'h1234_5678); rd(A_MLO, v); chk("R5 cmp lo rb", v, 32'h1234_5678);
    wr(A_MHI, 32'h9ABC_DEF0); rd(A_MHI, v); chk("R5 cmp hi rb", v, 32'h9ABC_DEF0);
    wr(A_CFG, 32'h0002_0001); rd(A_CFG, v); chk("R4 cfg rb", v, 32'h0002_0001);
    wr(A_CFG, 32'hFFFF_FFFF); rd(A_CFG, v); chk("R4 cfg rb ones", v, 32'hFFFF_FFFF);

    // R4 prescale/step sweep
    for (int p = 0; p < 4; p++) begin
      for (int s = 0; s < 3; s++) begin
        int st;
        st = (s == 0) ? 1 : (s == 1) ? 2 : 5;
        run(64'd1000, p, st, 23, r);
        chk($sformatf("R4 p=%0d step=%0d", p, st), r,
            64'd1000 + 64'((24 / (p + 1)) * st));
      end
    end
    run(64'h0000_0000_FFFF_FFFE, 0, 3, 4, r);
    chk("R4 carry", r, 64'h0000_0001_0000_000D);

    // R3 write priority over tick
    wr(A_CFG, 32'h0001_0000);
    wr(A_CLO, 100); wr(A_CHI, 0);
    wr(A_CTRL, 1);
    wr(A_CLO, 5);
    rd(A_CLO, v); chk("R3 write beats tick", v, 5);
    @(negedge clk);
    rd(A_CLO, v); chk("R3 run after write", v, 6);
    wr(A_CTRL, 0);

    // R6/R7/R9 compare sweep, step 1
    wr(A_CLO, 0); wr(A_CHI, 0);
    wr(A_MHI, 0); wr(A_MLO, 10);
    wr(A_IST, 1);
    wr(A_IEN, 1);
    rd(A_IST, v); chk("R7 cleared before run", v, 0);
    wr(A_CTRL, 1);
    sticky = 0;
    for (int i = 0; i < 20; i++) begin
      rd(A_CLO, v);
      chk($sformatf("R6 level c=%0d", v), machTimerIrq, (v >= 10));
      chk($sformatf("R7 sticky c=%0d", v), intrExpired, sticky);
      if (v >= 10) sticky = 1;
      @(negedge clk);
    end
    wr(A_CTRL, 0);

    // R6 pending compare asserts at once; step 0 holds counter while active
    wr(A_CFG, 32'h0);
    wr(A_CLO, 100);
    wr(A_MLO, 1000);
    wr(A_IST, 1);
    wr(A_CTRL, 1);
    chk("R6 cmp ahead low", machTimerIrq, 0);
    chk("R7 no state yet", intrExpired, 0);
    wr(A_MLO, 50);
    chk("R6 immediate on past cmp", machTimerIrq, 1);
    chk("R7 state one edge later", intrExpired, 0);
    @(negedge clk);
    chk("R7 state set", intrExpired, 1);
    wr(A_MLO, 1000);
    chk("R6 deassert cmp ahead", machTimerIrq, 0);
    chk("R7 sticky after deassert", intrExpired, 1);
    wr(A_IST, 1);
    chk("R7 w1c clears out", intrExpired, 0);
    rd(A_IST, v); chk("R7 w1c clears reg", v, 0);
    wr(A_IST, 0);
    wr(A_MLO, 50);
    @(negedge clk);
    wr(A_IST, 1);
    rd(A_IST, v); chk("R7 set wins over clear", v, 1);
    wr(A_MLO, 1000);
    wr(A_IST, 1);
    rd(A_IST, v); chk("R7 clear when idle", v, 0);

    // R8 / R9 test register and gating
    wr(A_IEN, 0);
    wr(A_ITST, 1);
    rd(A_IST, v); chk("R8 test sets state", v, 1);
    chk("R9 masked", intrExpired, 0);
    rd(A_ITST, v); chk("R8 itest reads 0", v, 0);
    wr(A_ALERT, 1);
    rd(A_ALERT, v); chk("R8 alert reads 0", v, 0);
    wr(A_IEN, 1);
    chk("R9 unmasked", intrExpired, 1);
    wr(A_IST, 1);
    chk("R9 after clear", intrExpired, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule